// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a two-part logical address, made of a segment number and a byte offset, into a flat 32-bit address. A small table of descriptors is held in registers. Each descriptor holds a present flag, a two-bit access-rights code, a base address and a length. A request carries the segment number, the offset and an access kind: read, write or instruction fetch. The block checks the request against the selected descriptor. When every check passes, it returns base plus offset. When a check fails, it reports a fault with a cause code.

Software loads descriptors through a single-cycle write port. Requests are accepted on any cycle that `req_valid` is high. The result appears exactly one cycle later, with a valid strobe, a fault flag, a cause code and the address.

Top module: `seg_xlate`

## Requirements
- R1: For a request with no fault, `out_addr` equals descriptor base plus offset, taken modulo 2^32, and `out_cause` is 0.
- R2: An offset greater than or equal to the descriptor length raises a bounds fault with cause code 3. A length of 0 rejects every offset.
- R3: A segment number at or above NUM_SEG (default 8) raises an invalid-segment fault with cause code 1.
- R4: A descriptor whose present flag is clear raises a not-present fault with cause code 2.
- R5: The rights code sets which accesses are allowed. Code 0 (read/write data) allows read and write. Code 1 (execute-only) allows fetch only. Code 2 (read-only data) allows read only. Code 3 (execute/read) allows fetch and read. Access kinds are encoded as 0 read, 1 write and 2 fetch; access kind 3 is never allowed. A refused access raises a protection fault with cause code 4.
- R6: When a request meets several fault conditions, only the first in this order is reported: invalid segment (1), not present (2), bounds (3), protection (4).
- R7: `out_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R8: A faulting result drives `out_fault` high and `out_addr` to 0. While `out_valid` is low, `out_fault` and `out_cause` are 0.
- R9: After reset, every descriptor is not present, and all outputs are 0.
- R10: A descriptor write with a segment number at or above NUM_SEG changes no descriptor.
- R11: A request in the same cycle as a write to the same segment is judged against the descriptor as it was before that write. The next request sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Descriptor write strobe |
| wr_seg | input | SEG_W | Segment number to write |
| wr_present | input | 1 | Present flag to store |
| wr_rights | input | 2 | Rights code to store |
| wr_base | input | ADDR_W | Base address to store |
| wr_limit | input | ADDR_W | Segment length to store |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Requested segment number |
| req_off | input | ADDR_W | Requested offset |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_fault | output | 1 | Result is a fault |
| out_cause | output | 3 | 0 none, 1 invalid segment, 2 not present, 3 bounds, 4 protection |
| out_addr | output | ADDR_W | Translated address, 0 on a fault |

## Verification
Two events can fall in the same cycle: a descriptor write and a translation of the same segment. The bench provokes this with directed cases, for example by making an absent segment present, and by shrinking a segment's length while a request arrives. It also issues random writes in the same cycle as requests. Each such result is judged against the bench's copy of the table as it stood before the write. The request that follows is judged against the updated copy. The bench also stacks several fault conditions in one request, to show that the priority order decides the reported cause.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    RT_DATA_RW   = 2'd0,
    RT_EXEC_ONLY = 2'd1,
    RT_DATA_RO   = 2'd2,
    RT_EXEC_RD   = 2'd3
  } rights_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_BADSEG = 3'd1,
    FLT_ABSENT = 3'd2,
    FLT_BOUNDS = 3'd3,
    FLT_PROT   = 3'd4
  } cause_e;

  // Access-rights matrix: returns 1 when the access kind is allowed.
  function automatic logic rights_allow(input rights_e rt, input acc_e acc);
    case (acc)
      ACC_READ:  rights_allow = (rt != RT_EXEC_ONLY);
      ACC_WRITE: rights_allow = (rt == RT_DATA_RW);
      ACC_FETCH: rights_allow = (rt == RT_EXEC_ONLY) || (rt == RT_EXEC_RD);
      default:   rights_allow = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int NUM_SEG = 8,
  parameter int SEG_W   = 3,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic              wr_present,
  input  logic [1:0]        wr_rights,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_limit,
  input  logic [SEG_W-1:0]  rd_seg,
  output logic              rd_oob,
  output logic              rd_present,
  output logic [1:0]        rd_rights,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_limit
);
  localparam logic [SEG_W:0] SEG_CNT = (SEG_W+1)'(NUM_SEG);

  typedef struct packed {
    logic              present;
    logic [1:0]        rights;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
  } desc_t;

  desc_t ents [NUM_SEG];
  logic  wr_in_range;

  assign wr_in_range = ({1'b0, wr_seg} < SEG_CNT);
  assign rd_oob      = ({1'b0, rd_seg} >= SEG_CNT);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && wr_in_range && (wr_seg == SEG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents[g] <= '0;
      end else if (hit) begin
        ents[g] <= '{present: wr_present, rights: wr_rights,
                     base: wr_base, limit: wr_limit};
      end
    end
  end

  desc_t sel;
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_seg == SEG_W'(i)) sel = ents[i];
    end
  end

  assign rd_present = sel.present;
  assign rd_rights  = sel.rights;
  assign rd_base    = sel.base;
  assign rd_limit   = sel.limit;
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              oob,
  input  logic              present,
  input  logic [1:0]        rights,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic [ADDR_W-1:0] off,
  input  logic [1:0]        acc,
  output logic              hit_badseg,
  output logic              hit_absent,
  output logic              hit_bounds,
  output logic              hit_prot,
  output logic [2:0]        cause,
  output logic [ADDR_W-1:0] phys
);
  function automatic logic off_legal(input logic [ADDR_W-1:0] o,
                                     input logic [ADDR_W-1:0] len);
    return o < len;
  endfunction

  function automatic logic [ADDR_W-1:0] lin_sum(input logic [ADDR_W-1:0] b,
                                                input logic [ADDR_W-1:0] o);
    return b + o;
  endfunction

  assign hit_badseg = oob;
  assign hit_absent = !present;
  assign hit_bounds = !off_legal(off, limit);
  assign hit_prot   = !rights_allow(rights_e'(rights), acc_e'(acc));

  always_comb begin
    if (hit_badseg)      cause = FLT_BADSEG;
    else if (hit_absent) cause = FLT_ABSENT;
    else if (hit_bounds) cause = FLT_BOUNDS;
    else if (hit_prot)   cause = FLT_PROT;
    else                 cause = FLT_NONE;
  end

  assign phys = (cause == FLT_NONE) ? lin_sum(base, off) : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int SEG_W   = 4,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic              wr_present,
  input  logic [1:0]        wr_rights,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_limit,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [1:0]        req_acc,
  output logic              out_valid,
  output logic              out_fault,
  output logic [2:0]        out_cause,
  output logic [ADDR_W-1:0] out_addr
);
  logic              d_oob, d_present;
  logic [1:0]        d_rights;
  logic [ADDR_W-1:0] d_base, d_limit;
  logic              hit_badseg, hit_absent, hit_bounds, hit_prot;
  logic [2:0]        nxt_cause;
  logic [ADDR_W-1:0] nxt_addr;

  seg_table #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .ADDR_W(ADDR_W)) tbl_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_present(wr_present),
    .wr_rights(wr_rights), .wr_base(wr_base), .wr_limit(wr_limit),
    .rd_seg(req_seg), .rd_oob(d_oob), .rd_present(d_present),
    .rd_rights(d_rights), .rd_base(d_base), .rd_limit(d_limit)
  );

  seg_check #(.ADDR_W(ADDR_W)) chk_i (
    .oob(d_oob), .present(d_present), .rights(d_rights),
    .base(d_base), .limit(d_limit), .off(req_off), .acc(req_acc),
    .hit_badseg(hit_badseg), .hit_absent(hit_absent),
    .hit_bounds(hit_bounds), .hit_prot(hit_prot),
    .cause(nxt_cause), .phys(nxt_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_cause <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= req_valid;
      out_fault <= req_valid && (nxt_cause != FLT_NONE);
      out_cause <= req_valid ? nxt_cause : 3'(FLT_NONE);
      out_addr  <= req_valid ? nxt_addr : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int NUM_SEG = 8,
  parameter int SEG_W   = 4,
  parameter int ADDR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [SEG_W-1:0]  req_seg,
  input logic              hit_badseg,
  input logic              hit_absent,
  input logic              hit_bounds,
  input logic              out_valid,
  input logic              out_fault,
  input logic [2:0]        out_cause,
  input logic [ADDR_W-1:0] out_addr
);
  localparam logic [SEG_W:0] SEG_CNT = (SEG_W+1)'(NUM_SEG);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  assert_badseg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_seg} >= SEG_CNT)) |=> (out_fault && out_cause == 3'd1));

  assert_absent_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit_badseg && hit_absent) |=> (out_cause == 3'd2));

  assert_bounds_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit_badseg && !hit_absent && hit_bounds) |=> (out_cause == 3'd3));

  assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (out_addr == '0));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_fault && out_cause == 3'd0));

  assert_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fault) |-> (out_cause == 3'd0));
endmodule

bind seg_xlate seg_xlate_chk #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .ADDR_W(ADDR_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
  .hit_badseg(hit_badseg), .hit_absent(hit_absent), .hit_bounds(hit_bounds),
  .out_valid(out_valid), .out_fault(out_fault), .out_cause(out_cause),
  .out_addr(out_addr)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  localparam int NSEG = 8;
  localparam int SW   = 4;
  localparam int AW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [SW-1:0] wr_seg = '0;
  logic          wr_present = 1'b0;
  logic [1:0]    wr_rights = '0;
  logic [AW-1:0] wr_base = '0, wr_limit = '0;
  logic          req_valid = 1'b0;
  logic [SW-1:0] req_seg = '0;
  logic [AW-1:0] req_off = '0;
  logic [1:0]    req_acc = '0;
  logic          out_valid, out_fault;
  logic [2:0]    out_cause;
  logic [AW-1:0] out_addr;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // bench copy of the descriptor table
  bit          m_pres [NSEG];
  int unsigned m_rt   [NSEG];
  int unsigned m_base [NSEG];
  int unsigned m_lim  [NSEG];

  always #10 clk = ~clk;

  seg_xlate #(.NUM_SEG(NSEG), .SEG_W(SW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_seg(wr_seg),
    .wr_present(wr_present), .wr_rights(wr_rights), .wr_base(wr_base),
    .wr_limit(wr_limit), .req_valid(req_valid), .req_seg(req_seg),
    .req_off(req_off), .req_acc(req_acc), .out_valid(out_valid),
    .out_fault(out_fault), .out_cause(out_cause), .out_addr(out_addr)
  );

  function automatic bit allowed(int unsigned rt, int unsigned acc);
    // rows: rights 0 rw, 1 exec-only, 2 read-only, 3 exec+read; cols: read, write, fetch
    bit [2:0] tbl [4] = '{3'b011, 3'b100, 3'b001, 3'b101};
    if (acc > 2) return 0;
    return tbl[rt][acc];
  endfunction

  function automatic int unsigned exp_cause(int unsigned seg, int unsigned off, int unsigned acc);
    if (seg >= NSEG) return 1;
    if (!m_pres[seg]) return 2;
    if (!(off < m_lim[seg])) return 3;
    if (!allowed(m_rt[seg], acc)) return 4;
    return 0;
  endfunction

  function automatic int unsigned exp_addr(int unsigned seg, int unsigned off, int unsigned acc);
    if (exp_cause(seg, off, acc) != 0) return 0;
    return m_base[seg] + off;
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp, string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_write(int unsigned seg, bit p, int unsigned rt, int unsigned b, int unsigned l);
    if (seg < NSEG) begin
      m_pres[seg] = p; m_rt[seg] = rt; m_base[seg] = b; m_lim[seg] = l;
    end
  endtask

  task automatic do_write(int unsigned seg, bit p, int unsigned rt, int unsigned b, int unsigned l);
    wr_en = 1; wr_seg = SW'(seg); wr_present = p; wr_rights = 2'(rt);
    wr_base = b; wr_limit = l;
    @(negedge clk);
    wr_en = 0;
    model_write(seg, p, rt, b, l);
  endtask

  // request, optionally with a write in the same cycle; judged against the old table
  task automatic do_req(string req, int unsigned seg, int unsigned off, int unsigned acc,
                        bit with_wr = 0, int unsigned wseg = 0, bit wp = 0,
                        int unsigned wrt = 0, int unsigned wb = 0, int unsigned wl = 0);
    int unsigned ec, ea;
    ec = exp_cause(seg, off, acc);
    ea = exp_addr(seg, off, acc);
    req_valid = 1; req_seg = SW'(seg); req_off = off; req_acc = 2'(acc);
    if (with_wr) begin
      wr_en = 1; wr_seg = SW'(wseg); wr_present = wp; wr_rights = 2'(wrt);
      wr_base = wb; wr_limit = wl;
    end
    @(negedge clk);
    req_valid = 0; wr_en = 0;
    if (with_wr) model_write(wseg, wp, wrt, wb, wl);
    check(req, {31'd0, out_valid}, 1, "out_valid");
    check(req, {31'd0, out_fault}, (ec != 0) ? 1 : 0, "out_fault");
    check(req, {29'd0, out_cause}, ec, "out_cause");
    check(req, out_addr, ea, "out_addr");
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    s = $urandom(32'h5e61);
    for (int i = 0; i < NSEG; i++) begin
      m_pres[i] = 0; m_rt[i] = 0; m_base[i] = 0; m_lim[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", {31'd0, out_valid}, 0, "out_valid");
    check("R9", {29'd0, out_cause}, 0, "out_cause");
    check("R9", out_addr, 0, "out_addr");
    rst_n = 1;
    @(negedge clk);
    do_req("R9", 3, 0, 0);   // every descriptor absent after reset
    // R7 idle
    @(negedge clk);
    check("R7", {31'd0, out_valid}, 0, "out_valid idle");
    check("R8", {31'd0, out_fault}, 0, "out_fault idle");

    do_write(2, 1, 0, 4300, 400);
    do_write(0, 1, 0, 32'h1000, 1000);
    do_write(1, 1, 1, 32'h8000, 256);
    do_write(3, 1, 2, 32'h2000, 64);
    do_write(4, 1, 3, 32'hFFFF_FFF0, 32'h100);
    do_req("R1", 2, 53, 0);
    do_req("R1", 4, 32'h20, 2);          // wraps modulo 2^32
    do_req("R2", 0, 1222, 0);
    do_req("R2", 2, 400, 1);             // offset equal to length
    do_req("R1", 2, 399, 1);             // last legal byte
    do_req("R3", 9, 0, 0);
    do_req("R3", 15, 5, 2);
    do_req("R4", 5, 0, 0);
    do_req("R5", 1, 4, 0);               // read of execute-only
    do_req("R5", 1, 4, 2);               // fetch of execute-only allowed
    do_req("R5", 0, 4, 2);               // fetch of data segment
    do_req("R5", 3, 4, 1);               // write of read-only
    do_req("R5", 4, 4, 0);               // read of exec+read allowed
    do_req("R5", 0, 4, 3);               // reserved access kind
    do_req("R6", 6, 32'hFFFF, 3);        // absent beats bounds and protection
    do_req("R6", 1, 300, 0);             // bounds beats protection
    do_write(0, 0, 0, 0, 0);
    do_req("R6", 0, 2000, 3);
    do_write(0, 1, 0, 32'h1000, 1000);
    do_write(5, 1, 0, 32'h3000, 0);
    do_req("R2", 5, 0, 0);               // zero length rejects offset 0
    // R10: write beyond the table is dropped
    do_write(9, 1, 0, 32'h7777, 100);
    do_req("R10", 9, 1, 0);
    do_req("R10", 1, 1, 2);
    // R11: same-cycle write and request
    do_req("R11", 6, 10, 0, 1, 6, 1, 0, 32'h9000, 50);
    do_req("R11", 6, 10, 0);
    do_req("R11", 2, 300, 0, 1, 2, 1, 0, 4300, 100);
    do_req("R11", 2, 300, 0);

    for (int n = 0; n < 400; n++) begin
      int unsigned seg, off, acc, lim;
      if (($urandom % 4) == 0) begin
        seg = $urandom % 10;
        lim = ($urandom % 3 == 0) ? $urandom : $urandom % 2000;
        if ($urandom % 2 == 0)
          do_req("R11", $urandom % 10, $urandom % 2500, $urandom % 4,
                 1, seg, ($urandom % 5) != 0, $urandom % 4, $urandom, lim);
        else
          do_write(seg, ($urandom % 5) != 0, $urandom % 4, $urandom, lim);
      end
      seg = $urandom % 10;
      off = ($urandom % 4 == 0) ? $urandom : $urandom % 2500;
      acc = $urandom % 4;
      do_req("R1", seg, off, acc);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule